// File: doc/BRIEF.md
# Dual-Port Memory with Address-Collision Arbitration

This block is a synchronous true dual-port static memory. Two identical ports, left and right, each with enable, output enable, a read/write select, an address and write data, share one word array. Both ports may read and write at any time. Conflicts arise only when both touch the same word, and then the block must decide which port may write. The default geometry is 1024 words of 8 bits. Setting `ADDR_W` to 13 gives the 8K-word part.

A `master` strap selects one of two roles. As master, the block compares the two enabled addresses. On a match it keeps the port that was there first and pulls the other port's active-low busy output low, which blocks that port's writes. As slave, the block does no arbitration: each port's busy output stays high, and an external active-low busy input per port gates that port's writes. This lets an external arbiter, such as a master device, decide who writes.

Reads are registered with one cycle of latency and always proceed, even on a busy port. Read data is forced to zero, and its valid flag is low, whenever the port was not reading with output enable in the previous cycle.

Top module: `dpr_mem`

## Requirements
- R1: After a synchronous reset, both `*_rvalid` are 0, both `*_rdata` are 0 and both `*_busy_n` are 1, whatever the arbitration state was before the reset.
- R2: A port writes `*_wdata` into `*_addr` at the rising edge when `*_en`=1, `*_rd`=0 and its write is not blocked. A port with `*_en`=1, `*_oe`=1 and `*_rd`=1 presents the word at `*_addr` on `*_rdata`, with `*_rvalid`=1, one cycle later.
- R3: When the port did not have `*_en`=1, `*_oe`=1 and `*_rd`=1 in the previous cycle, `*_rdata` is 0 and `*_rvalid` is 0.
- R4: In master mode (`master`=1), while both ports are enabled on equal addresses, exactly one port's `*_busy_n` is 0.
- R5: In master mode, when a match begins, a port whose enable was 1 and whose address was unchanged in the previous cycle wins, and the newly arrived port sees `*_busy_n`=0. The winner then keeps the grant for as long as the match lasts.
- R6: In master mode, when both ports arrive at a matching address in the same cycle, the left port wins and `r_busy_n` is 0.
- R7: While a port's `*_busy_n` is 0 in master mode, its writes do not change the memory, and its reads still return data.
- R8: A losing port's `*_busy_n` stays 0 for exactly one more cycle after the match ends, and writes stay blocked in that cycle.
- R9: In slave mode (`master`=0), both `*_busy_n` outputs are 1. A port's write happens only if its `*_busy_in_n` is 1, and equal addresses block nothing.
- R10: In master mode, `*_busy_in_n` has no effect on writes.
- R11: A read issued at the edge where the other port writes the same word returns the old word. A later read from either port returns the new word.
- R12: If both ports write the same word at the same edge (possible in slave mode), the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| master | input | 1 | 1 = master (arbitrate, drive busy), 0 = slave (busy is an input) |
| l_en | input | 1 | Left port enable |
| l_oe | input | 1 | Left output enable |
| l_rd | input | 1 | Left direction: 1 = read, 0 = write |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_busy_in_n | input | 1 | Left external write inhibit, active low, used in slave mode |
| l_busy_n | output | 1 | Left busy flag, active low |
| l_rdata | output | DATA_W | Left registered read data |
| l_rvalid | output | 1 | Left read data valid |
| r_en | input | 1 | Right port enable |
| r_oe | input | 1 | Right output enable |
| r_rd | input | 1 | Right direction: 1 = read, 0 = write |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_busy_in_n | input | 1 | Right external write inhibit, active low, used in slave mode |
| r_busy_n | output | 1 | Right busy flag, active low |
| r_rdata | output | DATA_W | Right registered read data |
| r_rvalid | output | 1 | Right read data valid |

## Verification
The bench targets the arrival-order cases: a newcomer colliding with a port that has held its address, a tie where both arrive together, and a later right-side winner. An arbiter that ranks by fixed priority instead of by arrival would give the wrong port busy and store the wrong byte. It checks the one-cycle release tail by writing during that cycle; a design releasing busy immediately would overwrite the word. It checks read-first behaviour against a simultaneous write; a write-first memory would return the new byte a cycle early. In slave mode it shows that an external inhibit blocks a write and that the busy inputs are ignored in master mode; mixing the two roles would corrupt memory or block legal writes.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
   typedef enum logic [1:0] {
      GR_NONE  = 2'd0,
      GR_LEFT  = 2'd1,
      GR_RIGHT = 2'd2
   } grant_e;
endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              master,
   input  logic              l_en,
   input  logic              r_en,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [ADDR_W-1:0] r_addr,
   output logic              l_lose,
   output logic              r_lose
);
   import dpr_pkg::*;

   grant_e            grant_q, grant_d;
   logic              l_en_q, r_en_q;
   logic [ADDR_W-1:0] l_addr_q, r_addr_q;
   logic              l_lose_q, r_lose_q;
   logic              hit, l_fresh, r_fresh;

   // previous-cycle view of each port, used only to rank arrival order
   always_ff @(posedge clk) begin
      l_en_q   <= l_en;
      r_en_q   <= r_en;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
   end

   always_comb begin
      hit     = master && l_en && r_en && (l_addr == r_addr);
      l_fresh = !(l_en_q && (l_addr_q == l_addr));
      r_fresh = !(r_en_q && (r_addr_q == r_addr));
      if (!hit)
         grant_d = GR_NONE;
      else if (grant_q != GR_NONE)
         grant_d = grant_q;
      else if (l_fresh && !r_fresh)
         grant_d = GR_RIGHT;
      else
         grant_d = GR_LEFT;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         grant_q  <= GR_NONE;
         l_lose_q <= 1'b0;
         r_lose_q <= 1'b0;
      end else begin
         grant_q  <= grant_d;
         l_lose_q <= (grant_d == GR_RIGHT);
         r_lose_q <= (grant_d == GR_LEFT);
      end
   end

   assign l_lose = (grant_d == GR_RIGHT) || l_lose_q;
   assign r_lose = (grant_d == GR_LEFT)  || r_lose_q;
endmodule

// File: rtl/dpr_rdport.sv
module dpr_rdport #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_act,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);
   always_ff @(posedge clk) begin
      if (rst) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rdata  <= rd_act ? word : '0;
         rvalid <= rd_act;
      end
   end
endmodule

// File: rtl/dpr_mem.sv
module dpr_mem #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              master,
   input  logic              l_en,
   input  logic              l_oe,
   input  logic              l_rd,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   input  logic              l_busy_in_n,
   output logic              l_busy_n,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_rvalid,
   input  logic              r_en,
   input  logic              r_oe,
   input  logic              r_rd,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   input  logic              r_busy_in_n,
   output logic              r_busy_n,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_rvalid
);
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int NPORTS = 2;

   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("dpr_mem: ADDR_W out of range");
   end
   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data
      $error("dpr_mem: DATA_W out of range");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   // index 0 = left, index 1 = right
   logic [NPORTS-1:0] p_en, p_oe, p_rd, p_bin, p_lose, p_we, p_busy_n, p_rvalid;
   logic [ADDR_W-1:0] p_addr  [NPORTS];
   logic [DATA_W-1:0] p_wdata [NPORTS];
   logic [DATA_W-1:0] p_rdata [NPORTS];

   assign p_en       = {r_en, l_en};
   assign p_oe       = {r_oe, l_oe};
   assign p_rd       = {r_rd, l_rd};
   assign p_bin      = {r_busy_in_n, l_busy_in_n};
   assign p_addr[0]  = l_addr;
   assign p_addr[1]  = r_addr;
   assign p_wdata[0] = l_wdata;
   assign p_wdata[1] = r_wdata;

   dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
      .clk    (clk),
      .rst    (rst),
      .master (master),
      .l_en   (l_en),
      .r_en   (r_en),
      .l_addr (l_addr),
      .r_addr (r_addr),
      .l_lose (p_lose[0]),
      .r_lose (p_lose[1])
   );

   for (genvar g = 0; g < NPORTS; g++) begin : g_port
      logic wr_ok;
      assign wr_ok       = master ? !p_lose[g] : p_bin[g];
      assign p_we[g]     = p_en[g] && !p_rd[g] && wr_ok;
      assign p_busy_n[g] = master ? !p_lose[g] : 1'b1;

      dpr_rdport #(.DATA_W(DATA_W)) u_rd (
         .clk    (clk),
         .rst    (rst),
         .rd_act (p_en[g] && p_oe[g] && p_rd[g]),
         .word   (mem[p_addr[g]]),
         .rdata  (p_rdata[g]),
         .rvalid (p_rvalid[g])
      );
   end

   // right first, left last: left data lands when both hit one word
   always_ff @(posedge clk) begin
      if (p_we[1]) mem[p_addr[1]] <= p_wdata[1];
      if (p_we[0]) mem[p_addr[0]] <= p_wdata[0];
   end

   assign l_busy_n = p_busy_n[0];
   assign r_busy_n = p_busy_n[1];
   assign l_rdata  = p_rdata[0];
   assign r_rdata  = p_rdata[1];
   assign l_rvalid = p_rvalid[0];
   assign r_rvalid = p_rvalid[1];
endmodule

// File: rtl/dpr_mem_chk.sv
module dpr_mem_chk #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              master,
   input logic              l_en,
   input logic              l_oe,
   input logic              l_rd,
   input logic [ADDR_W-1:0] l_addr,
   input logic [DATA_W-1:0] l_wdata,
   input logic              l_busy_in_n,
   input logic              l_busy_n,
   input logic [DATA_W-1:0] l_rdata,
   input logic              l_rvalid,
   input logic              r_en,
   input logic              r_oe,
   input logic              r_rd,
   input logic [ADDR_W-1:0] r_addr,
   input logic [DATA_W-1:0] r_wdata,
   input logic              r_busy_in_n,
   input logic              r_busy_n,
   input logic [DATA_W-1:0] r_rdata,
   input logic              r_rvalid
);
   logic mm;
   assign mm = master && l_en && r_en && (l_addr == r_addr);

   assert_one_loser_R4: assert property (@(posedge clk) disable iff (rst)
      mm |-> ($countones({~l_busy_n, ~r_busy_n}) == 1));

   assert_holder_wins_R5: assert property (@(posedge clk) disable iff (rst)
      (mm && !$past(mm) && $past(l_en) && ($past(l_addr) == l_addr) && !$past(r_en))
      |-> (l_busy_n && !r_busy_n));

   assert_tie_left_R6: assert property (@(posedge clk) disable iff (rst)
      (mm && !$past(mm) && !$past(l_en) && !$past(r_en)) |-> (l_busy_n && !r_busy_n));

   assert_release_tail_R8: assert property (@(posedge clk) disable iff (rst)
      (!l_busy_n || !r_busy_n) |-> (mm || $past(mm)));

   assert_slave_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      !master |-> (l_busy_n && r_busy_n));

   assert_l_valid_src_R3: assert property (@(posedge clk) disable iff (rst)
      l_rvalid |-> $past(l_en && l_oe && l_rd));

   assert_r_valid_src_R3: assert property (@(posedge clk) disable iff (rst)
      r_rvalid |-> $past(r_en && r_oe && r_rd));
endmodule

bind dpr_mem dpr_mem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dpr_mem_test.sv
`timescale 1ns/1ps
module dpr_mem_test;
   localparam int AW = 10;
   localparam int DW = 8;
   localparam int NV = 21;

   typedef struct packed {
      logic          md;
      logic          le, lo, lr;
      logic [AW-1:0] la;
      logic [DW-1:0] ld;
      logic          lbi;
      logic          re, ro, rr;
      logic [AW-1:0] ra;
      logic [DW-1:0] rd;
      logic          rbi;
      logic          xl, xr;
   } vec_t;

   // md | le lo lr la ld lbi | re ro rr ra rd rbi | exp l_busy_n r_busy_n
   localparam vec_t TBL [NV] = '{
      '{1'b1, 1'b1,1'b0,1'b0,10'd5, 8'h11,1'b1, 1'b0,1'b0,1'b1,10'd0, 8'h00,1'b1, 1'b1,1'b1},
      '{1'b1, 1'b1,1'b1,1'b1,10'd5, 8'h00,1'b1, 1'b1,1'b0,1'b0,10'd6, 8'h22,1'b1, 1'b1,1'b1},
      '{1'b1, 1'b0,1'b0,1'b1,10'd0, 8'h00,1'b1, 1'b1,1'b1,1'b1,10'd5, 8'h00,1'b1, 1'b1,1'b1},
      '{1'b1, 1'b0,1'b0,1'b1,10'd0, 8'h00,1'b1, 1'b0,1'b0,1'b1,10'd0, 8'h00,1'b1, 1'b1,1'b1},
      '{1'b1, 1'b1,1'b0,1'b0,10'd7, 8'h33,1'b1, 1'b1,1'b0,1'b0,10'd7, 8'h44,1'b1, 1'b1,1'b0},
      '{1'b1, 1'b0,1'b0,1'b1,10'd0, 8'h00,1'b1, 1'b0,1'b0,1'b1,10'd0, 8'h00,1'b1, 1'b1,1'b0},
      '{1'b1, 1'b0,1'b0,1'b1,10'd0, 8'h00,1'b1, 1'b1,1'b1,1'b1,10'd7, 8'h00,1'b1, 1'b1,1'b1},
      '{1'b1, 1'b1,1'b0,1'b0,10'd8, 8'h55,1'b1, 1'b0,1'b0,1'b1,10'd0, 8'h00,1'b1, 1'b1,1'b1},
      '{1'b1, 1'b1,1'b0,1'b0,10'd8, 8'h66,1'b1, 1'b1,1'b0,1'b0,10'd8, 8'h77,1'b1, 1'b1,1'b0},
      '{1'b1, 1'b0,1'b0,1'b1,10'd0, 8'h00,1'b1, 1'b1,1'b0,1'b0,10'd8, 8'h88,1'b1, 1'b1,1'b0},
      '{1'b1, 1'b0,1'b0,1'b1,10'd0, 8'h00,1'b1, 1'b1,1'b1,1'b1,10'd8, 8'h00,1'b1, 1'b1,1'b1},
      '{1'b1, 1'b0,1'b0,1'b1,10'd0, 8'h00,1'b1, 1'b1,1'b0,1'b0,10'd9, 8'h12,1'b1, 1'b1,1'b1},
      '{1'b1, 1'b1,1'b1,1'b1,10'd9, 8'h00,1'b1, 1'b1,1'b0,1'b0,10'd9, 8'h13,1'b1, 1'b0,1'b1},
      '{1'b1, 1'b1,1'b1,1'b1,10'd9, 8'h00,1'b1, 1'b0,1'b0,1'b1,10'd0, 8'h00,1'b1, 1'b0,1'b1},
      '{1'b0, 1'b1,1'b0,1'b0,10'd10,8'hA1,1'b1, 1'b1,1'b0,1'b0,10'd10,8'hB2,1'b1, 1'b1,1'b1},
      '{1'b0, 1'b0,1'b0,1'b1,10'd0, 8'h00,1'b1, 1'b1,1'b0,1'b0,10'd10,8'hC3,1'b0, 1'b1,1'b1},
      '{1'b0, 1'b1,1'b1,1'b1,10'd10,8'h00,1'b1, 1'b0,1'b0,1'b1,10'd0, 8'h00,1'b1, 1'b1,1'b1},
      '{1'b0, 1'b1,1'b0,1'b0,10'd12,8'h5A,1'b1, 1'b0,1'b0,1'b1,10'd0, 8'h00,1'b1, 1'b1,1'b1},
      '{1'b1, 1'b1,1'b0,1'b0,10'd12,8'h5B,1'b0, 1'b0,1'b0,1'b1,10'd0, 8'h00,1'b1, 1'b1,1'b1},
      '{1'b1, 1'b0,1'b0,1'b1,10'd0, 8'h00,1'b1, 1'b1,1'b1,1'b1,10'd12,8'h00,1'b1, 1'b1,1'b1},
      '{1'b1, 1'b1,1'b0,1'b1,10'd5, 8'h00,1'b1, 1'b0,1'b0,1'b1,10'd0, 8'h00,1'b1, 1'b1,1'b1}
   };

   function automatic string tag_of(int i);
      case (i)
         0, 1, 7, 11: return "R2";
         2:           return "R11";
         3:           return "R4";
         4:           return "R4 R6";
         5:           return "R8";
         6:           return "R6 R7";
         8:           return "R5";
         9:           return "R8 R7";
         10:          return "R7";
         12:          return "R5 R11";
         13:          return "R7 R8";
         14:          return "R9 R12";
         15, 16, 17:  return "R9";
         18, 19:      return "R10";
         default:     return "R3";
      endcase
   endfunction

   logic          clk = 1'b0;
   logic          rst;
   logic          master;
   logic          l_en, l_oe, l_rd, l_busy_in_n, l_busy_n, l_rvalid;
   logic [AW-1:0] l_addr;
   logic [DW-1:0] l_wdata, l_rdata;
   logic          r_en, r_oe, r_rd, r_busy_in_n, r_busy_n, r_rvalid;
   logic [AW-1:0] r_addr;
   logic [DW-1:0] r_wdata, r_rdata;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;
   logic [DW-1:0] ref_mem [1 << AW];

   always #2.5 clk = ~clk;

   dpr_mem #(.ADDR_W(AW), .DATA_W(DW)) uut (.*);

   task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic drive(vec_t v);
      master = v.md;
      l_en = v.le; l_oe = v.lo; l_rd = v.lr; l_addr = v.la; l_wdata = v.ld; l_busy_in_n = v.lbi;
      r_en = v.re; r_oe = v.ro; r_rd = v.rr; r_addr = v.ra; r_wdata = v.rd; r_busy_in_n = v.rbi;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #100000;
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
   end

   initial begin
      vec_t idle;
      idle = '{1'b1, 1'b0,1'b0,1'b1,10'd0,8'h00,1'b1, 1'b0,1'b0,1'b1,10'd0,8'h00,1'b1, 1'b1,1'b1};
      drive(idle);
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      #1;
      check("R1", {31'd0, l_rvalid}, 32'd0, "l_rvalid after reset");
      check("R1", {31'd0, r_rvalid}, 32'd0, "r_rvalid after reset");
      check("R1", {24'd0, l_rdata}, 32'd0, "l_rdata after reset");
      check("R1", {30'd0, l_busy_n, r_busy_n}, 32'd3, "busy_n after reset");

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         logic          lrd_exp, rrd_exp, wl, wr;
         logic [DW-1:0] ldat_exp, rdat_exp;
         v = TBL[i];
         @(negedge clk);
         drive(v);
         #1;
         check(tag_of(i), {31'd0, l_busy_n}, {31'd0, v.xl}, $sformatf("l_busy_n vec %0d", i));
         check(tag_of(i), {31'd0, r_busy_n}, {31'd0, v.xr}, $sformatf("r_busy_n vec %0d", i));
         lrd_exp  = v.le && v.lo && v.lr;
         rrd_exp  = v.re && v.ro && v.rr;
         ldat_exp = lrd_exp ? ref_mem[v.la] : '0;
         rdat_exp = rrd_exp ? ref_mem[v.ra] : '0;
         wl = v.le && !v.lr && (v.md ? v.xl : v.lbi);
         wr = v.re && !v.rr && (v.md ? v.xr : v.rbi);
         if (wr) ref_mem[v.ra] = v.rd;
         if (wl) ref_mem[v.la] = v.ld;
         @(posedge clk);
         #1;
         check(tag_of(i), {31'd0, l_rvalid}, {31'd0, lrd_exp}, $sformatf("l_rvalid vec %0d", i));
         check(tag_of(i), {24'd0, l_rdata}, {24'd0, ldat_exp}, $sformatf("l_rdata vec %0d", i));
         check(tag_of(i), {31'd0, r_rvalid}, {31'd0, rrd_exp}, $sformatf("r_rvalid vec %0d", i));
         check(tag_of(i), {24'd0, r_rdata}, {24'd0, rdat_exp}, $sformatf("r_rdata vec %0d", i));
      end

      // R1: reset while a collision is active clears busy and read state
      @(negedge clk);
      drive('{1'b1, 1'b1,1'b1,1'b1,10'd5,8'h00,1'b1, 1'b1,1'b0,1'b0,10'd5,8'hEE,1'b1, 1'b1,1'b0});
      #1;
      check("R4", {30'd0, l_busy_n, r_busy_n}, 32'd2, "busy_n during collision");
      @(negedge clk);
      drive(idle);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      check("R1", {30'd0, l_busy_n, r_busy_n}, 32'd3, "busy_n after mid-run reset");
      check("R1", {30'd0, l_rvalid, r_rvalid}, 32'd0, "rvalid after mid-run reset");

      // R7: right write at address 5 was blocked by the collision, word still 11
      @(negedge clk);
      drive('{1'b1, 1'b1,1'b1,1'b1,10'd5,8'h00,1'b1, 1'b0,1'b0,1'b1,10'd0,8'h00,1'b1, 1'b1,1'b1});
      @(posedge clk);
      #1;
      check("R7", {24'd0, l_rdata}, {24'd0, ref_mem[5]}, "word 5 after blocked write");
      @(negedge clk);
      drive(idle);
      @(posedge clk);
      #1;
      finish_run();
   end
endmodule